// File: doc/BRIEF.md
# GPIO Task and Event Channel Bank

This block holds eight pin channels. Each channel is tied to one pin of a pin bank through a select field. A channel runs in one of three ways. When disabled it leaves its pin alone. In task mode it owns the pin's output and changes it when software fires a task. In event mode it watches the pin for a chosen kind of transition and records a sticky flag when that transition happens.

Software reaches the block through a small word-wide port. Each write is a single-cycle strobe; reads are combinational from the address. The port carries one configuration word per channel and one task register. A single write to the task register can fire output, set and clear actions on any channels at once. The port also carries the event-flag register and a pair of registers that set and clear interrupt enables. A single interrupt line reports any flagged channel whose enable is on.

Top module: `gte_bank`

## Requirements
- R1: After reset every configuration word, the event flags, the interrupt enables, `irq` and every `pin_oe` bit read 0.
- R2: Configuration word for channel n sits at address n (0 to 7). Mode is in bits [1:0], polarity in bits [5:4], initial level in bit [8] and pin select in bits [23:16], and the word reads back as written in those fields. Mode 0 (off) or 2 (reserved) takes no control of the pin, so its `pin_oe` bit stays 0.
- R3: Writing a configuration word with mode 3 (task) drives the selected pin from the edge of that write onward. `pin_oe` goes to 1 and `pin_out` takes the initial-level bit.
- R4: The task register is at address 8, with output-action bits [7:0], set bits [15:8] and clear bits [23:16] (bit n for channel n). A task-mode channel whose output-action bit is written changes its pin as its polarity says: 0 keeps the level, 1 drives high, 2 drives low, 3 inverts.
- R5: For a task-mode channel, a set bit drives the pin high and a clear bit drives it low, whatever the polarity.
- R6: When one task-register write hits the same channel with several actions, clear wins over set, and set wins over the output action.
- R7: Task actions aimed at a channel that is not in task mode have no effect. Its pin stays undriven and no event flag appears.
- R8: In mode 1 (event), polarity 1 flags a rising pin level, 2 a falling one, 3 any change, and 0 nothing. A pin change present at clock edge t sets the flag by edge t+2 and not earlier.
- R9: Event flags read at address 9, bit n for channel n. A flag stays set until software writes 1 to its bit there. Writing 0 leaves it set.
- R10: Writing 1s to address 10 turns on the matching interrupt enables, and writing 1s to address 11 turns them off. Zero bits change nothing, and both addresses read back the current enables.
- R11: `irq` is 1 exactly when some channel has both its event flag and its interrupt enable set.
- R12: When several task-mode channels select the same pin, the lowest-numbered one drives it.
- R13: Writing a configuration word never raises an event by itself, even when the new pin select points to a pin with a different level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels seen from the pads, asynchronous |
| pin_oe | output | 16 | Per-pin output enable, set where a task-mode channel owns the pin |
| pin_out | output | 16 | Per-pin output level |
| irq | output | 1 | Interrupt request |

## Verification
A channel holding the wrong output state shows it on its pin one edge after the task write that should have set it. A corrupted mode or select shows up at once as a wrong output-enable bit. An edge detector that has lost its previous pin sample, or that was not re-armed after a configuration write, shows a flag that is set when it should be clear, or clear when it should be set, two edges after the pin moves. That wrong flag also reaches `irq` in the same cycle. The random phase compares every task-mode pin, the whole flag register and `irq` against a model after each step. The directed tests pin down the exact edge at which a flag appears and the cases where actions collide.

// File: rtl/gte_pkg.sv
package gte_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int LANE        = 8;   // bits per action lane in the task register

    localparam logic [ADDR_W-1:0] A_TASK    = 4'h8;
    localparam logic [ADDR_W-1:0] A_FLAG    = 4'h9;
    localparam logic [ADDR_W-1:0] A_IEN_SET = 4'hA;
    localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'hB;

    localparam int F_MODE = 0;
    localparam int F_POL  = 4;
    localparam int F_INIT = 8;
    localparam int F_PSEL = 16;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_EVENT = 2'd1,
        MODE_RSVD  = 2'd2,
        MODE_TASK  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_RISE = 2'd1,
        POL_FALL = 2'd2,
        POL_ANY  = 2'd3
    } pol_e;

    typedef struct packed {
        logic [7:0] psel;
        logic       init;
        pol_e       pol;
        mode_e      mode;
    } chcfg_t;

    function automatic chcfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        chcfg_t c;
        c.mode = mode_e'(w[F_MODE +: 2]);
        c.pol  = pol_e'(w[F_POL +: 2]);
        c.init = w[F_INIT];
        c.psel = w[F_PSEL +: 8];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input chcfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[F_MODE +: 2] = c.mode;
        w[F_POL +: 2]  = c.pol;
        w[F_INIT]      = c.init;
        w[F_PSEL +: 8] = c.psel;
        return w;
    endfunction

    // Task-mode next level: clear beats set beats output action.
    function automatic logic task_next(input logic cur, input pol_e pol,
                                       input logic act, input logic set, input logic clr);
        logic n;
        n = cur;
        if (clr)      n = 1'b0;
        else if (set) n = 1'b1;
        else if (act) begin
            case (pol)
                POL_RISE: n = 1'b1;
                POL_FALL: n = 1'b0;
                POL_ANY:  n = ~cur;
                default:  n = cur;
            endcase
        end
        return n;
    endfunction

    function automatic logic edge_hit(input pol_e pol, input logic was, input logic now);
        case (pol)
            POL_RISE: return ~was & now;
            POL_FALL: return was & ~now;
            POL_ANY:  return was ^ now;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gte_sync.sv
module gte_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gte_channel.sv
module gte_channel
    import gte_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int PSW  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  chcfg_t          cfg_wr,
    input  logic            t_act,
    input  logic            t_set,
    input  logic            t_clr,
    input  logic [NPIN-1:0] pin_sync,
    input  logic            flag_clr,
    output chcfg_t          cfg,
    output logic            drive_en,
    output logic            drive_val,
    output logic [PSW-1:0]  drive_pin,
    output logic            flag
);
    chcfg_t cfg_q;
    logic   out_q;
    logic   prev_q;
    logic   armed_q;
    logic   flag_q;
    logic   cur;
    logic   hit;

    assign cur = pin_sync[cfg_q.psel[PSW-1:0]];
    assign hit = armed_q && (cfg_q.mode == MODE_EVENT) && edge_hit(cfg_q.pol, prev_q, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            out_q   <= 1'b0;
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q   <= cfg_wr;
                armed_q <= 1'b0;
                if (cfg_wr.mode == MODE_TASK) out_q <= cfg_wr.init;
            end else begin
                armed_q <= 1'b1;
                if (cfg_q.mode == MODE_TASK)
                    out_q <= task_next(out_q, cfg_q.pol, t_act, t_set, t_clr);
            end
            prev_q <= cur;
            flag_q <= hit | (flag_q & ~flag_clr);
        end
    end

    assign cfg       = cfg_q;
    assign drive_en  = (cfg_q.mode == MODE_TASK);
    assign drive_val = out_q;
    assign drive_pin = cfg_q.psel[PSW-1:0];
    assign flag      = flag_q;

    AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wr.mode == MODE_TASK |=> out_q == $past(cfg_wr.init)); // R3
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mode == MODE_TASK && !cfg_we && t_set && !t_clr |=> out_q); // R5
    AST_CLR_FIRST: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mode == MODE_TASK && !cfg_we && t_clr |=> !out_q); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mode != MODE_TASK && !cfg_we |=> $stable(out_q)); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode != MODE_EVENT || cfg_q.pol == POL_NONE) && !flag_q |=> !flag_q); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_q && !flag_clr |=> flag_q); // R9
    AST_REARM_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) && !flag_q |=> !flag_q); // R13
endmodule

// File: rtl/gte_pin_mux.sv
module gte_pin_mux #(
    parameter int NCH  = 8,
    parameter int NPIN = 16,
    parameter int PSW  = 4
) (
    input  logic [NCH-1:0]          drive_en,
    input  logic [NCH-1:0]          drive_val,
    input  logic [NCH-1:0][PSW-1:0] drive_pin,
    output logic [NPIN-1:0]         pin_oe,
    output logic [NPIN-1:0]         pin_out
);
    // Walk from the highest channel down so the lowest one writes last and wins.
    always_comb begin
        pin_oe  = '0;
        pin_out = '0;
        for (int ch = NCH - 1; ch >= 0; ch--) begin
            if (drive_en[ch]) begin
                pin_oe[drive_pin[ch]]  = 1'b1;
                pin_out[drive_pin[ch]] = drive_val[ch];
            end
        end
    end
endmodule

// File: rtl/gte_bank.sv
module gte_bank
    import gte_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_out,
    output logic              irq
);
    localparam int PSW = $clog2(NPIN);

    logic [NPIN-1:0]          pin_sync;
    chcfg_t                   cfg_v [NCH];
    logic [NCH-1:0]           drive_en;
    logic [NCH-1:0]           drive_val;
    logic [NCH-1:0][PSW-1:0]  drive_pin;
    logic [NCH-1:0]           flags;
    logic [NCH-1:0]           ien_q;
    logic                     wr_task;
    logic                     wr_flag;
    logic                     wr_ien_set;
    logic                     wr_ien_clr;
    logic [7:0]               unused_wdata;

    assign unused_wdata = bus_wdata[31:24];

    assign wr_task    = bus_we && bus_addr == A_TASK;
    assign wr_flag    = bus_we && bus_addr == A_FLAG;
    assign wr_ien_set = bus_we && bus_addr == A_IEN_SET;
    assign wr_ien_clr = bus_we && bus_addr == A_IEN_CLR;

    gte_sync #(.W(NPIN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        gte_channel #(.NPIN(NPIN), .PSW(PSW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (bus_we && bus_addr == ADDR_W'(ch)),
            .cfg_wr    (cfg_from_word(bus_wdata)),
            .t_act     (wr_task && bus_wdata[ch]),
            .t_set     (wr_task && bus_wdata[LANE + ch]),
            .t_clr     (wr_task && bus_wdata[2*LANE + ch]),
            .pin_sync  (pin_sync),
            .flag_clr  (wr_flag && bus_wdata[ch]),
            .cfg       (cfg_v[ch]),
            .drive_en  (drive_en[ch]),
            .drive_val (drive_val[ch]),
            .drive_pin (drive_pin[ch]),
            .flag      (flags[ch])
        );
    end

    gte_pin_mux #(.NCH(NCH), .NPIN(NPIN), .PSW(PSW)) u_mux (
        .drive_en  (drive_en),
        .drive_val (drive_val),
        .drive_pin (drive_pin),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    always_ff @(posedge clk) begin
        if (rst)             ien_q <= '0;
        else if (wr_ien_set) ien_q <= ien_q | bus_wdata[NCH-1:0];
        else if (wr_ien_clr) ien_q <= ien_q & ~bus_wdata[NCH-1:0];
    end

    assign irq = |(flags & ien_q);

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NCH; ch++)
            if (bus_addr == ADDR_W'(ch)) bus_rdata = cfg_to_word(cfg_v[ch]);
        case (bus_addr)
            A_FLAG:                 bus_rdata = WORD_W'(flags);
            A_IEN_SET, A_IEN_CLR:   bus_rdata = WORD_W'(ien_q);
            default: ;
        endcase
    end

    AST_IEN_SET: assert property (@(posedge clk) disable iff (rst)
        wr_ien_set |=> (ien_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])); // R10
    AST_IEN_CLR: assert property (@(posedge clk) disable iff (rst)
        wr_ien_clr |=> (ien_q & $past(bus_wdata[NCH-1:0])) == '0); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ien_q == '0 |-> !irq); // R11
endmodule

// File: tb/gte_bank_tb.sv
module gte_bank_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gte_bank u_dut (
        .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
        .pin_oe (pin_oe), .pin_out (pin_out), .irq (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Config word: mode [1:0], polarity [5:4], init [8], pin select [23:16].
    function automatic logic [31:0] cw(input int mode, input int pol, input int init, input int psel);
        return {8'h0, 8'(psel), 7'h0, 1'(init), 2'h0, 2'(pol), 2'h0, 2'(mode)};
    endfunction

    function automatic logic exp_out(input logic cur, input int pol, input logic a, input logic s, input logic c);
        if (c) return 1'b0;
        if (s) return 1'b1;
        if (a) begin
            if (pol == 1) return 1'b1;
            if (pol == 2) return 1'b0;
            if (pol == 3) return ~cur;
        end
        return cur;
    endfunction

    function automatic logic exp_evt(input int pol, input logic was, input logic now);
        if (pol == 1) return ~was & now;
        if (pol == 2) return was & ~now;
        if (pol == 3) return was ^ now;
        return 1'b0;
    endfunction

    // Drive at a falling edge; returns at the next falling edge, after the write has landed.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  mo;
        int          tpol [4];
        int          epol [4];
        logic [3:0]  ien;
        logic [3:0]  eflag;
        void'($urandom(32'd1357));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, d); chk("R1 cfg0", d, 0);
        rd(4'h9, d); chk("R1 flags", d, 0);
        rd(4'hA, d); chk("R1 ien", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin_oe", pin_oe, 0);

        // R2 off and reserved modes do not drive
        wr(4'h0, cw(0, 3, 1, 5)); chk("R2 off oe", pin_oe, 0);
        wr(4'h0, cw(2, 3, 1, 5)); chk("R2 rsvd oe", pin_oe, 0);

        // R3 task init level; R2 read-back
        wr(4'h0, cw(3, 0, 1, 5));
        chk("R3 oe", pin_oe, 16'h0020); chk("R3 out", pin_out[5], 1);
        rd(4'h0, d); chk("R2 readback", d, cw(3, 0, 1, 5));

        // R4 output action per polarity
        wr(4'h8, 32'h1); chk("R4 none keeps", pin_out[5], 1);
        wr(4'h0, cw(3, 3, 0, 5)); chk("R3 init low", pin_out[5], 0);
        wr(4'h8, 32'h1); chk("R4 toggle up", pin_out[5], 1);
        wr(4'h8, 32'h1); chk("R4 toggle down", pin_out[5], 0);
        wr(4'h0, cw(3, 1, 0, 5)); wr(4'h8, 32'h1); chk("R4 pol1 high", pin_out[5], 1);
        wr(4'h0, cw(3, 2, 1, 5)); wr(4'h8, 32'h1); chk("R4 pol2 low", pin_out[5], 0);

        // R5 set and clear ignore polarity
        wr(4'h0, cw(3, 2, 0, 5));
        wr(4'h8, 32'h100); chk("R5 set", pin_out[5], 1);
        wr(4'h0, cw(3, 1, 1, 5));
        wr(4'h8, 32'h10000); chk("R5 clr", pin_out[5], 0);

        // R6 priority
        wr(4'h0, cw(3, 3, 1, 5));
        wr(4'h8, 32'h10101); chk("R6 clr wins", pin_out[5], 0);
        wr(4'h8, 32'h100);
        wr(4'h8, 32'h101); chk("R6 set over toggle", pin_out[5], 1);

        // R12 shared pin, lowest channel drives
        wr(4'h1, cw(3, 0, 0, 5)); chk("R12 ch0 wins", pin_out[5], 1);
        wr(4'h0, cw(0, 0, 0, 0)); chk("R12 ch1 after", pin_out[5], 0);
        chk("R12 oe", pin_oe, 16'h0020);
        wr(4'h1, cw(0, 0, 0, 0));

        // R7 strobes on a non-task channel
        wr(4'h2, cw(0, 3, 1, 6));
        wr(4'h8, 32'h00404); idle(3);
        chk("R7 oe", pin_oe, 0); chk("R7 out", pin_out, 0);
        rd(4'h9, d); chk("R7 flags", d, 0);

        // R8 timing on rising edge
        wr(4'h3, cw(1, 1, 0, 9)); idle(3);
        pin_in[9] = 1'b1;
        @(negedge clk); rd(4'h9, d); chk("R8 t", d[3], 0);
        @(negedge clk); rd(4'h9, d); chk("R8 t+1", d[3], 0);
        @(negedge clk); rd(4'h9, d); chk("R8 t+2", d[3], 1);

        // R11 irq gating
        chk("R11 masked", irq, 0);
        wr(4'hA, 32'h8); chk("R11 enabled", irq, 1);

        // R9 sticky and clear
        pin_in[9] = 1'b0; idle(4);
        rd(4'h9, d); chk("R9 sticky", d[3], 1);
        wr(4'h9, 32'h0); rd(4'h9, d); chk("R9 write0", d[3], 1);
        wr(4'h9, 32'h8); rd(4'h9, d); chk("R9 clear", d[3], 0);
        chk("R11 cleared", irq, 0);

        // R13 reconfig to a pin at another level
        pin_in[10] = 1'b1; pin_in[9] = 1'b0; idle(4);
        wr(4'h3, cw(1, 3, 0, 10)); idle(5);
        rd(4'h9, d); chk("R13 no event", d[3], 0);
        wr(4'h3, cw(0, 0, 0, 0));

        // R10 enable set/clear
        wr(4'hB, 32'hFF);
        wr(4'hA, 32'h05); rd(4'hA, d); chk("R10 set", d, 32'h05);
        rd(4'hB, d); chk("R10 read clr addr", d, 32'h05);
        wr(4'hA, 32'h00); rd(4'hA, d); chk("R10 set0", d, 32'h05);
        wr(4'hB, 32'h04); rd(4'hA, d); chk("R10 clr", d, 32'h01);
        wr(4'hB, 32'h00); rd(4'hA, d); chk("R10 clr0", d, 32'h01);
        wr(4'hB, 32'hFF);

        // Random phase: ch0..3 task on pins 0..3, ch4..7 event on pins 12..15
        pin_in = '0; idle(4);
        for (int c = 0; c < 4; c++) begin
            tpol[c] = int'($urandom_range(0, 3));
            mo[c]   = 1'($urandom_range(0, 1));
            wr(4'(c), cw(3, tpol[c], int'(mo[c]), c));
            epol[c] = int'($urandom_range(0, 3));
            wr(4'(c + 4), cw(1, epol[c], 0, c + 12));
        end
        ien = 4'($urandom_range(0, 15));
        wr(4'hA, {24'h0, ien, 4'h0});
        idle(3);
        wr(4'h9, 32'hFF);
        chk("R3 random init", pin_out[3:0], mo);

        for (int it = 0; it < 150; it++) begin
            logic [3:0] a, s, c, np, op;
            a = 4'($urandom); s = 4'($urandom); c = 4'($urandom);
            if (($urandom % 5) == 0) begin s = 4'hF; c = 4'($urandom); end
            op = pin_in[15:12]; np = 4'($urandom);
            for (int k = 0; k < 4; k++) begin
                mo[k]    = exp_out(mo[k], tpol[k], a[k], s[k], c[k]);
                eflag[k] = exp_evt(epol[k], op[k], np[k]);
            end
            @(negedge clk);
            pin_in[15:12] = np;
            bus_we = 1'b1; bus_addr = 4'h8;
            bus_wdata = {8'h0, 4'h0, c, 4'h0, s, 4'h0, a};
            @(negedge clk); bus_we = 1'b0;
            chk("R4 R5 R6 random pins", pin_out[3:0], mo);
            idle(2);
            rd(4'h9, d); chk("R8 random flags", d, {24'h0, eflag, 4'h0});
            chk("R11 random irq", irq, |(eflag & ien));
            wr(4'h9, 32'hFF);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule